// File: doc/BRIEF.md
# DDR2 Device Command State Tracker

This block follows the command-level behaviour of a DDR2 SDRAM device. A decoded command, a bank number, a clock-enable level and a small mode field arrive on every clock. From these the block keeps:

- the global device state;
- the condition of each of the eight banks;
- the programmed latencies and burst length.

It flags any command that the current state does not allow. It also produces pulses that mark the clocks in which read data and write data would be on the bus.

A controller model or a memory-side monitor uses the block to check a command stream against the device rules. The bank-activation time, the refresh duration and the refresh interval are parameters, so a bench can run with short intervals. Electrical behaviour, delay-locked loop lock, termination and data storage are not modelled.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: After reset, dev_state_o is 0 (initializing), bank_open_o is 0 and every flag is low. In that state only NOP (0), MRS (1), EMRS (2) and PREA (9) are accepted. The state becomes 1 (idle) at the clock edge where both an MRS and an EMRS have been accepted, in either order.
- R2: MRS takes CAS latency from mode_i[2:0] and burst length 8 (else 4) from mode_i[3]. EMRS takes additive latency from mode_i[2:0]. A CAS latency outside 3..6, an additive latency above 4, or either write while any bank is not closed is illegal and changes nothing.
- R3: ACT (3) to a closed bank sets its bank_open_o bit at the next edge, and dev_state_o reads 2 (active) while any bank is not closed. The bank accepts reads and writes only from RCD_CYC clocks after the ACT. ACT to a bank that is not closed is illegal.
- R4: RD (4), WR (5), RDA (6) and WRA (7) are legal only to a bank whose activation time has elapsed and that has no pending auto-precharge.
- R5: rd_valid_o is high for burst/2 clocks. It rises AL+CL clocks after the edge that accepted RD or RDA.
- R6: wr_valid_o is high for burst/2 clocks. It rises AL+CL-1 clocks after the edge that accepted WR or WRA.
- R7: RDA closes its bank AL+CL+burst/2 clocks after acceptance, and WRA closes its bank AL+CL-1+burst/2 clocks after acceptance. While the close is pending, any command that names that bank is illegal, except PREA.
- R8: PRE (8) closes the named open bank at the next edge. PRE is a legal no-op on a closed bank and is illegal on a bank that is still activating or closing. PREA closes every bank at the next edge.
- R9: REF (10) with clock enable high and every bank closed makes dev_state_o 3 for RFC_CYC clocks, then 1. REF with any bank not closed is illegal. Any command other than NOP while refreshing is illegal.
- R10: With clock enable low and NOP in the idle or active state, dev_state_o becomes 5 if every bank is closed, otherwise 6. Clock enable high returns to the previous state. Any command other than NOP during power-down is illegal.
- R11: SREF (11) with clock enable low and every bank closed makes dev_state_o 4. The state holds while clock enable stays low and returns to 1 on the first clock with clock enable high.
- R12: refresh_due_o rises REFI_CYC clocks after the latest of three events: leaving initialization, an accepted REF, or a clock spent in self refresh. It drops at the edge that accepts the next REF.
- R13: illegal_o rises at the edge after an illegal command and stays high until reset. An illegal command leaves the device state and the banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock-enable level |
| cmd_i | input | 4 | Decoded command code |
| bank_i | input | 3 | Target bank |
| mode_i | input | 4 | Mode field for MRS and EMRS |
| dev_state_o | output | 3 | Device state code |
| bank_open_o | output | 8 | One bit per bank, set while the bank is not closed |
| illegal_o | output | 1 | Sticky illegal-command flag |
| rd_valid_o | output | 1 | Read data window |
| wr_valid_o | output | 1 | Write data window |
| refresh_due_o | output | 1 | Refresh overdue |

## Verification
The assertions assume three things about the inputs:

- reset is held for at least one clock before any command;
- latency values reach the data-window logic only through accepted mode writes;
- a burst-window start always carries a latency between 1 and the largest read latency.

The stimulus draws CAS latency only from 3..6 and additive latency only from 0..4. It opens a bank before it reads or writes that bank, and it resets the device before each illegal-command case. This is needed because the sticky flag would otherwise hide later illegal commands.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;

  localparam logic [3:0] C_NOP  = 4'd0;
  localparam logic [3:0] C_MRS  = 4'd1;
  localparam logic [3:0] C_EMRS = 4'd2;
  localparam logic [3:0] C_ACT  = 4'd3;
  localparam logic [3:0] C_RD   = 4'd4;
  localparam logic [3:0] C_WR   = 4'd5;
  localparam logic [3:0] C_RDA  = 4'd6;
  localparam logic [3:0] C_WRA  = 4'd7;
  localparam logic [3:0] C_PRE  = 4'd8;
  localparam logic [3:0] C_PREA = 4'd9;
  localparam logic [3:0] C_REF  = 4'd10;
  localparam logic [3:0] C_SREF = 4'd11;

  typedef enum logic [2:0] {
    D_INIT    = 3'd0,
    D_IDLE    = 3'd1,
    D_ACTIVE  = 3'd2,
    D_REFRESH = 3'd3,
    D_SELFREF = 3'd4,
    D_PRE_PD  = 3'd5,
    D_ACT_PD  = 3'd6
  } dev_state_e;

  typedef enum logic [1:0] {
    B_CLOSED  = 2'd0,
    B_OPENING = 2'd1,
    B_OPEN    = 2'd2,
    B_CLOSING = 2'd3
  } bank_state_e;

endpackage

// File: rtl/ddr2_bank_fsm.sv
module ddr2_bank_fsm
  import ddr2_trk_pkg::*;
#(
  parameter int RCD_CYC = 3,   // at least 2
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_i,
  input  logic          ap_i,
  input  logic [CW-1:0] ap_len_i,
  input  logic          close_i,
  output bank_state_e   state_o
);

  bank_state_e   st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= B_CLOSED;
      cnt_q <= '0;
    end else if (close_i) begin
      st_q  <= B_CLOSED;
      cnt_q <= '0;
    end else if (act_i) begin
      st_q  <= B_OPENING;
      cnt_q <= CW'(RCD_CYC - 1);
    end else if (ap_i) begin
      st_q  <= B_CLOSING;
      cnt_q <= ap_len_i;
    end else begin
      case (st_q)
        B_OPENING: begin
          if (cnt_q == CW'(1)) st_q <= B_OPEN;
          cnt_q <= cnt_q - CW'(1);
        end
        B_CLOSING: begin
          if (cnt_q == CW'(1)) st_q <= B_CLOSED;
          cnt_q <= cnt_q - CW'(1);
        end
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign state_o = st_q;

  assert_act_from_closed_R3: assert property (@(posedge clk) disable iff (rst)
    act_i |-> st_q == B_CLOSED) else $error("activate to non-closed bank");

  assert_ap_from_open_R7: assert property (@(posedge clk) disable iff (rst)
    ap_i |-> st_q == B_OPEN) else $error("auto-precharge on bank not open");

  assert_close_next_R8: assert property (@(posedge clk) disable iff (rst)
    close_i |=> st_q == B_CLOSED) else $error("bank not closed after close");

endmodule

// File: rtl/ddr2_burst_window.sv
module ddr2_burst_window #(
  parameter int MAX_LAT = 10,
  parameter int LW      = 4,
  parameter int HW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic [LW-1:0] lat_i,
  input  logic [HW-1:0] half_i,
  output logic          valid_o
);

  logic [MAX_LAT-1:0] dl_q, dl_d;
  logic [HW-1:0]      left_q;

  always_comb begin
    dl_d = dl_q >> 1;
    if (issue_i) dl_d = dl_d | (MAX_LAT'(1) << (lat_i - LW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dl_q    <= '0;
      left_q  <= '0;
      valid_o <= 1'b0;
    end else begin
      dl_q <= dl_d;
      if (dl_q[0]) begin
        valid_o <= 1'b1;
        left_q  <= half_i - HW'(1);
      end else if (left_q != '0) begin
        valid_o <= 1'b1;
        left_q  <= left_q - HW'(1);
      end else begin
        valid_o <= 1'b0;
      end
    end
  end

  assert_lat_range_R5: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> (lat_i >= LW'(1)) && (int'(lat_i) <= MAX_LAT))
    else $error("burst latency out of range");

  assert_window_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && left_q == '0 && !dl_q[0]) |=> !valid_o)
    else $error("data window overran");

endmodule

// File: rtl/ddr2_refresh_timer.sv
module ddr2_refresh_timer #(
  parameter int REFI_CYC = 1950,
  localparam int CW = $clog2(REFI_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic clear_i,
  output logic due_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (run_i && cnt_q != CW'(REFI_CYC)) cnt_q <= cnt_q + CW'(1);
  end

  assign due_o = (cnt_q == CW'(REFI_CYC));

  assert_due_clear_R12: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !due_o) else $error("refresh due not cleared");

  assert_due_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (due_o && !clear_i) |=> due_o) else $error("refresh due dropped early");

endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
  import ddr2_trk_pkg::*;
#(
  parameter int N_BANKS  = 8,
  parameter int RCD_CYC  = 3,
  parameter int RFC_CYC  = 5,
  parameter int REFI_CYC = 1950,
  parameter int MIN_CL   = 3,
  parameter int MAX_CL   = 6,
  parameter int MAX_AL   = 4,
  localparam int BA_W    = $clog2(N_BANKS),
  localparam int MAX_LAT = MAX_AL + MAX_CL,
  localparam int LW      = $clog2(MAX_LAT + 1),
  localparam int HW      = 3,
  localparam int AP_W    = $clog2(MAX_LAT + 4 + 1),
  localparam int RF_W    = $clog2(RFC_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cke_i,
  input  logic [3:0]         cmd_i,
  input  logic [BA_W-1:0]    bank_i,
  input  logic [3:0]         mode_i,
  output logic [2:0]         dev_state_o,
  output logic [N_BANKS-1:0] bank_open_o,
  output logic               illegal_o,
  output logic               rd_valid_o,
  output logic               wr_valid_o,
  output logic               refresh_due_o
);

  dev_state_e       st_q;
  logic [2:0]       cl_q, al_q;
  logic             bl8_q, got_mr_q, got_emr_q, illegal_q;
  logic [RF_W-1:0]  rfc_q;

  bank_state_e      bst [N_BANKS];
  bank_state_e      sel_st;
  logic             all_closed;
  logic             cl_ok, al_ok, ok, run_cmd;
  logic [LW-1:0]    rl, wl;
  logic [HW-1:0]    half;
  logic [AP_W-1:0]  ap_len;
  logic             acc_mrs, acc_emrs, acc_ref, acc_sref;
  logic             rd_issue, wr_issue;
  logic [N_BANKS-1:0] act_v, ap_v, close_v;

  // decode of current configuration and bank view
  always_comb begin
    all_closed = 1'b1;
    for (int i = 0; i < N_BANKS; i++)
      if (bst[i] != B_CLOSED) all_closed = 1'b0;
  end

  assign sel_st = bst[bank_i];
  assign cl_ok  = (int'(mode_i[2:0]) >= MIN_CL) && (int'(mode_i[2:0]) <= MAX_CL);
  assign al_ok  = int'(mode_i[2:0]) <= MAX_AL;
  assign rl     = LW'(al_q) + LW'(cl_q);
  assign wl     = rl - LW'(1);
  assign half   = bl8_q ? HW'(4) : HW'(2);
  assign ap_len = (cmd_i == C_RDA) ? AP_W'(rl) + AP_W'(half)
                                   : AP_W'(wl) + AP_W'(half);

  // legality of the presented command
  always_comb begin
    ok = (cmd_i == C_NOP);
    case (st_q)
      D_INIT: begin
        if (cke_i)
          ok = (cmd_i == C_NOP) || (cmd_i == C_PREA) ||
               (cmd_i == C_MRS && cl_ok) || (cmd_i == C_EMRS && al_ok);
      end
      D_IDLE: begin
        if (!cke_i) begin
          ok = (cmd_i == C_NOP) || (cmd_i == C_SREF && all_closed);
        end else begin
          case (cmd_i)
            C_NOP:  ok = 1'b1;
            C_MRS:  ok = all_closed && cl_ok;
            C_EMRS: ok = all_closed && al_ok;
            C_ACT:  ok = (sel_st == B_CLOSED);
            C_RD, C_WR, C_RDA, C_WRA: ok = (sel_st == B_OPEN);
            C_PRE:  ok = (sel_st == B_CLOSED) || (sel_st == B_OPEN);
            C_PREA: ok = 1'b1;
            C_REF:  ok = all_closed;
            default: ok = 1'b0;
          endcase
        end
      end
      default: ok = (cmd_i == C_NOP);
    endcase
  end

  assign run_cmd  = ok && (st_q == D_IDLE) && cke_i;
  assign acc_mrs  = ok && cke_i && (cmd_i == C_MRS) && (st_q == D_INIT || st_q == D_IDLE);
  assign acc_emrs = ok && cke_i && (cmd_i == C_EMRS) && (st_q == D_INIT || st_q == D_IDLE);
  assign acc_ref  = run_cmd && (cmd_i == C_REF);
  assign acc_sref = ok && !cke_i && (st_q == D_IDLE) && (cmd_i == C_SREF);
  assign rd_issue = run_cmd && (cmd_i == C_RD || cmd_i == C_RDA);
  assign wr_issue = run_cmd && (cmd_i == C_WR || cmd_i == C_WRA);

  // per-bank strobes and bank machines
  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    assign act_v[g]   = run_cmd && (cmd_i == C_ACT) && (bank_i == BA_W'(g));
    assign ap_v[g]    = run_cmd && (cmd_i == C_RDA || cmd_i == C_WRA) && (bank_i == BA_W'(g));
    assign close_v[g] = run_cmd && ((cmd_i == C_PREA) ||
                                    (cmd_i == C_PRE && bank_i == BA_W'(g)));
    ddr2_bank_fsm #(.RCD_CYC(RCD_CYC), .CW(AP_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .act_i    (act_v[g]),
      .ap_i     (ap_v[g]),
      .ap_len_i (ap_len),
      .close_i  (close_v[g]),
      .state_o  (bst[g])
    );
    assign bank_open_o[g] = (bst[g] != B_CLOSED);
  end

  // global device state and mode registers
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= D_INIT;
      cl_q      <= 3'(MIN_CL);
      al_q      <= 3'd0;
      bl8_q     <= 1'b0;
      got_mr_q  <= 1'b0;
      got_emr_q <= 1'b0;
      rfc_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= illegal_q | !ok;
      if (acc_mrs) begin
        cl_q  <= mode_i[2:0];
        bl8_q <= mode_i[3];
      end
      if (acc_emrs) al_q <= mode_i[2:0];
      case (st_q)
        D_INIT: begin
          got_mr_q  <= got_mr_q | acc_mrs;
          got_emr_q <= got_emr_q | acc_emrs;
          if ((got_mr_q | acc_mrs) && (got_emr_q | acc_emrs)) st_q <= D_IDLE;
        end
        D_IDLE: begin
          if (acc_sref) begin
            st_q <= D_SELFREF;
          end else if (!cke_i && ok) begin
            st_q <= all_closed ? D_PRE_PD : D_ACT_PD;
          end else if (acc_ref) begin
            st_q  <= D_REFRESH;
            rfc_q <= RF_W'(RFC_CYC);
          end
        end
        D_REFRESH: begin
          if (rfc_q == RF_W'(1)) st_q <= D_IDLE;
          rfc_q <= rfc_q - RF_W'(1);
        end
        D_SELFREF, D_PRE_PD, D_ACT_PD: begin
          if (cke_i) st_q <= D_IDLE;
        end
        default: st_q <= D_INIT;
      endcase
    end
  end

  ddr2_burst_window #(.MAX_LAT(MAX_LAT), .LW(LW), .HW(HW)) u_rd_win (
    .clk (clk), .rst (rst), .issue_i (rd_issue), .lat_i (rl),
    .half_i (half), .valid_o (rd_valid_o)
  );

  ddr2_burst_window #(.MAX_LAT(MAX_LAT), .LW(LW), .HW(HW)) u_wr_win (
    .clk (clk), .rst (rst), .issue_i (wr_issue), .lat_i (wl),
    .half_i (half), .valid_o (wr_valid_o)
  );

  ddr2_refresh_timer #(.REFI_CYC(REFI_CYC)) u_refi (
    .clk     (clk),
    .rst     (rst),
    .run_i   (st_q != D_INIT && st_q != D_SELFREF),
    .clear_i (acc_ref || st_q == D_SELFREF),
    .due_o   (refresh_due_o)
  );

  assign illegal_o   = illegal_q;
  assign dev_state_o = (st_q == D_IDLE && !all_closed) ? D_ACTIVE : st_q;

  assert_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> illegal_o) else $error("illegal flag cleared");

  assert_bad_keeps_state_R13: assert property (@(posedge clk) disable iff (rst)
    (st_q == D_IDLE && !ok) |=> st_q == D_IDLE) else $error("illegal command moved state");

  assert_init_closed_R1: assert property (@(posedge clk) disable iff (rst)
    st_q == D_INIT |-> bank_open_o == '0) else $error("bank open during init");

  assert_ref_closed_R9: assert property (@(posedge clk) disable iff (rst)
    st_q == D_REFRESH |-> bank_open_o == '0) else $error("bank open during refresh");

  assert_ppd_closed_R10: assert property (@(posedge clk) disable iff (rst)
    st_q == D_PRE_PD |-> bank_open_o == '0) else $error("bank open in precharge power-down");

  assert_selfref_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == D_SELFREF && !cke_i) |=> st_q == D_SELFREF) else $error("left self refresh early");

endmodule

// File: tb/tb_ddr2_cmd_tracker.sv
`timescale 1ns/1ps
module tb_ddr2_cmd_tracker;

  localparam int RCD = 3;
  localparam int RFC = 5;
  localparam int REFI = 60;

  localparam logic [3:0] K_NOP = 4'd0, K_MRS = 4'd1, K_EMRS = 4'd2, K_ACT = 4'd3,
                         K_RD = 4'd4, K_WR = 4'd5, K_RDA = 4'd6, K_WRA = 4'd7,
                         K_PRE = 4'd8, K_PREA = 4'd9, K_REF = 4'd10, K_SREF = 4'd11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic [3:0] cmd = 4'd0;
  logic [2:0] bank = 3'd0;
  logic [3:0] mode = 4'd0;
  logic [2:0] dev_state;
  logic [7:0] bank_open;
  logic       illegal, rd_valid, wr_valid, refresh_due;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ddr2_cmd_tracker #(.RCD_CYC(RCD), .RFC_CYC(RFC), .REFI_CYC(REFI)) dut (
    .clk (clk), .rst (rst), .cke_i (cke), .cmd_i (cmd), .bank_i (bank),
    .mode_i (mode), .dev_state_o (dev_state), .bank_open_o (bank_open),
    .illegal_o (illegal), .rd_valid_o (rd_valid), .wr_valid_o (wr_valid),
    .refresh_due_o (refresh_due)
  );

  function automatic bit exp_win(int k, int lat, int h);
    return (k >= lat) && (k < lat + h);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] c, input int b, input logic [3:0] m, input logic k);
    cmd = c; bank = 3'(b); mode = m; cke = k;
    @(negedge clk);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) cyc(K_NOP, 0, 4'd0, 1'b1);
  endtask

  task automatic reset_init(int cl, int al, bit bl8);
    rst = 1'b1;
    nops(3);
    rst = 1'b0;
    cyc(K_MRS, 0, {bl8, 3'(cl)}, 1'b1);
    cyc(K_EMRS, 0, {1'b0, 3'(al)}, 1'b1);
  endtask

  // after the issuing cycle, watch the window for span clocks
  task automatic watch(string req, bit is_rd, int lat, int h, int span);
    int miss = 0;
    int first_k = -1;
    int first_v = 0;
    for (int k = 1; k <= span; k++) begin
      nops(1);
      if ((is_rd ? rd_valid : wr_valid) != exp_win(k, lat, h)) begin
        miss++;
        if (first_k < 0) begin first_k = k; first_v = is_rd ? rd_valid : wr_valid; end
      end
    end
    if (first_k >= 0) $display("  window mismatch at clock %0d value %0d", first_k, first_v);
    check(req, miss, 0);
  endtask

  initial begin
    nops(3);
    // R1 reset state
    check("R1 reset state", dev_state, 0);
    check("R1 reset banks", bank_open, 0);
    check("R1 reset illegal", illegal, 0);
    check("R1 reset rd_valid", rd_valid, 0);
    check("R1 reset wr_valid", wr_valid, 0);
    check("R1 reset due", refresh_due, 0);
    rst = 1'b0;
    cyc(K_ACT, 0, 4'd0, 1'b1);
    check("R1 act in init flagged", illegal, 1);
    check("R13 init state kept", dev_state, 0);
    check("R13 no bank opened", bank_open, 0);

    // R2 bad CAS latency
    rst = 1'b1; nops(2); rst = 1'b0;
    cyc(K_MRS, 0, 4'd7, 1'b1);
    check("R2 bad CL flagged", illegal, 1);
    cyc(K_EMRS, 0, 4'd0, 1'b1);
    check("R2 bad MRS not counted", dev_state, 0);

    // R1 init sequence then basic traffic
    rst = 1'b1; nops(2); rst = 1'b0;
    cyc(K_MRS, 0, 4'd3, 1'b1);
    check("R1 still init after MRS", dev_state, 0);
    cyc(K_EMRS, 0, 4'd0, 1'b1);
    check("R1 idle after EMRS", dev_state, 1);
    cyc(K_ACT, 2, 4'd0, 1'b1);
    check("R3 bank2 open", bank_open, 8'h04);
    check("R3 active state", dev_state, 2);
    nops(2);
    cyc(K_RD, 2, 4'd0, 1'b1);
    watch("R5 read window CL3 AL0 BL4", 1'b1, 3, 2, 7);
    check("R4 legal read accepted", illegal, 0);
    cyc(K_WR, 2, 4'd0, 1'b1);
    watch("R6 write window CL3 AL0 BL4", 1'b0, 2, 2, 6);
    cyc(K_PRE, 2, 4'd0, 1'b1);
    check("R8 pre closes bank", bank_open, 0);
    check("R8 back to idle", dev_state, 1);
    check("R8 no illegal", illegal, 0);

    // R3 read before activation time
    reset_init(3, 0, 1'b0);
    cyc(K_ACT, 1, 4'd0, 1'b1);
    nops(1);
    cyc(K_RD, 1, 4'd0, 1'b1);
    check("R3 early read flagged", illegal, 1);

    // R4 read to closed bank
    reset_init(3, 0, 1'b0);
    cyc(K_RD, 5, 4'd0, 1'b1);
    check("R4 read closed bank flagged", illegal, 1);
    check("R13 state kept", dev_state, 1);

    // R3 double activate
    reset_init(3, 0, 1'b0);
    cyc(K_ACT, 3, 4'd0, 1'b1);
    cyc(K_ACT, 3, 4'd0, 1'b1);
    check("R3 double act flagged", illegal, 1);
    check("R13 bank3 still open", bank_open, 8'h08);

    // R5 R6 longer latencies, burst 8
    reset_init(4, 1, 1'b1);
    cyc(K_ACT, 0, 4'd0, 1'b1);
    nops(2);
    cyc(K_WR, 0, 4'd0, 1'b1);
    watch("R6 write window CL4 AL1 BL8", 1'b0, 4, 4, 10);
    cyc(K_RD, 0, 4'd0, 1'b1);
    watch("R5 read window CL4 AL1 BL8", 1'b1, 5, 4, 11);

    // R7 read with auto precharge closes after 5 clocks
    reset_init(3, 0, 1'b0);
    cyc(K_ACT, 6, 4'd0, 1'b1);
    nops(2);
    cyc(K_RDA, 6, 4'd0, 1'b1);
    begin
      int miss = 0;
      for (int k = 1; k <= 5; k++) begin
        nops(1);
        if (bank_open[6] != (k < 5)) miss++;
      end
      check("R7 auto precharge close time", miss, 0);
    end
    check("R7 idle after auto precharge", dev_state, 1);
    check("R7 no illegal", illegal, 0);

    // R7 command to closing bank
    reset_init(3, 0, 1'b0);
    cyc(K_ACT, 6, 4'd0, 1'b1);
    nops(2);
    cyc(K_WRA, 6, 4'd0, 1'b1);
    nops(1);
    cyc(K_RD, 6, 4'd0, 1'b1);
    check("R7 read to closing bank flagged", illegal, 1);

    // R8 precharge all
    reset_init(3, 0, 1'b0);
    cyc(K_ACT, 1, 4'd0, 1'b1);
    cyc(K_ACT, 4, 4'd0, 1'b1);
    check("R3 two banks open", bank_open, 8'h12);
    nops(2);
    cyc(K_PREA, 0, 4'd0, 1'b1);
    check("R8 prea closes all", bank_open, 0);
    check("R8 prea legal", illegal, 0);

    // R8 precharge on activating bank
    reset_init(3, 0, 1'b0);
    cyc(K_ACT, 2, 4'd0, 1'b1);
    cyc(K_PRE, 2, 4'd0, 1'b1);
    check("R8 pre on opening flagged", illegal, 1);

    // R9 refresh duration
    reset_init(3, 0, 1'b0);
    cyc(K_REF, 0, 4'd0, 1'b1);
    check("R9 refreshing", dev_state, 3);
    begin
      int miss = 0;
      for (int k = 1; k <= RFC; k++) begin
        nops(1);
        if (dev_state != ((k < RFC) ? 3 : 1)) miss++;
      end
      check("R9 refresh length", miss, 0);
    end
    check("R9 no illegal", illegal, 0);

    reset_init(3, 0, 1'b0);
    cyc(K_REF, 0, 4'd0, 1'b1);
    cyc(K_ACT, 0, 4'd0, 1'b1);
    check("R9 act during refresh flagged", illegal, 1);

    reset_init(3, 0, 1'b0);
    cyc(K_ACT, 0, 4'd0, 1'b1);
    nops(2);
    cyc(K_REF, 0, 4'd0, 1'b1);
    check("R9 ref with open bank flagged", illegal, 1);
    check("R13 still active", dev_state, 2);

    // R10 power-down kinds
    reset_init(3, 0, 1'b0);
    cyc(K_NOP, 0, 4'd0, 1'b0);
    check("R10 precharge power-down", dev_state, 5);
    cyc(K_NOP, 0, 4'd0, 1'b0);
    check("R10 stays down", dev_state, 5);
    cyc(K_NOP, 0, 4'd0, 1'b1);
    check("R10 exit to idle", dev_state, 1);
    cyc(K_ACT, 7, 4'd0, 1'b1);
    cyc(K_NOP, 0, 4'd0, 1'b0);
    check("R10 active power-down", dev_state, 6);
    cyc(K_NOP, 0, 4'd0, 1'b1);
    check("R10 exit to active", dev_state, 2);
    check("R10 no illegal", illegal, 0);

    reset_init(3, 0, 1'b0);
    cyc(K_NOP, 0, 4'd0, 1'b0);
    cyc(K_ACT, 0, 4'd0, 1'b0);
    check("R10 command in power-down flagged", illegal, 1);
    check("R13 power-down bank kept closed", bank_open, 0);

    // R11 self refresh
    reset_init(3, 0, 1'b0);
    cyc(K_SREF, 0, 4'd0, 1'b0);
    check("R11 self refresh", dev_state, 4);
    for (int i = 0; i < 3; i++) cyc(K_NOP, 0, 4'd0, 1'b0);
    check("R11 held with cke low", dev_state, 4);
    cyc(K_NOP, 0, 4'd0, 1'b1);
    check("R11 exit to idle", dev_state, 1);
    check("R11 no illegal", illegal, 0);

    // R12 refresh interval
    reset_init(3, 0, 1'b0);
    nops(REFI - 1);
    check("R12 not yet due", refresh_due, 0);
    nops(1);
    check("R12 due", refresh_due, 1);
    cyc(K_REF, 0, 4'd0, 1'b1);
    check("R12 cleared by ref", refresh_due, 0);

    // R5 R6 constrained random configurations
    void'($urandom(32'd2718));
    for (int it = 0; it < 10; it++) begin
      int cl = 3 + int'($urandom % 4);
      int al = int'($urandom % 5);
      bit b8 = 1'($urandom % 2);
      int bk = int'($urandom % 8);
      bit is_rd = 1'($urandom % 2);
      int lat = is_rd ? cl + al : cl + al - 1;
      int h = b8 ? 4 : 2;
      reset_init(cl, al, b8);
      cyc(K_ACT, bk, 4'd0, 1'b1);
      nops(RCD - 1);
      cyc(is_rd ? K_RD : K_WR, bk, 4'd0, 1'b1);
      watch(is_rd ? "R5 random read window" : "R6 random write window", is_rd, lat, h, lat + h + 2);
      check("R4 random access legal", illegal, 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule